// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block is a shared 32-bit clamping datapath for a processor execute stage. A single opcode selects one of several operations: signed or unsigned add and subtract that clamp at the range limits, an add that wraps its result but still reports overflow, a doubling that clamps, and saturation of a word, or of two halfwords independently, to a programmable bit position. Every operation produces a 32-bit result and may raise a saturation event.

Saturation events build up in a sticky flag. The flag is set on any clock edge where a valid operation clamps or overflows. Later arithmetic never clears it. Only the dedicated clear input clears it, so software can run a block of operations and then test once whether any of them saturated. By default the result is registered. It appears on the clock edge after the valid strobe and holds until the next strobe.

The unit has no states. The only storage is the result register and the sticky flag register, and each updates under the enable conditions stated below.

Top module: `sat_arith_unit`

## Requirements
- R1: Opcode 0 is signed add. The result is the wrapped sum unless the operands have equal sign bits and the sum's sign bit differs from them. In that case the result is 0x7FFFFFFF when operand A is non-negative, 0x80000000 when A is negative, and an event is raised.
- R2: Opcode 1 is signed subtract A−B. Overflow is when A and B have different sign bits and the difference's sign differs from A's. On overflow the result clamps by A's sign exactly as in R1 and an event is raised.
- R3: Opcode 2 is unsigned add, which gives 0xFFFFFFFF with an event on carry out. Opcode 3 is unsigned subtract A−B, which gives 0 with an event when B exceeds A. Otherwise each gives the exact result.
- R4: Opcode 4 is the flag-only add. It always returns the wrapped sum A+B and raises an event on signed overflow as defined in R1.
- R5: Opcode 5 doubles operand A. Signed inputs of 0x40000000 or more give 0x7FFFFFFF, and signed inputs of 0xC0000000 or less give 0x80000000, both with an event. All other inputs give A shifted left by one with no event.
- R6: Opcode 6 clamps signed A into −2^n … 2^n−1, where n is `sat_pos`. Opcode 7 clamps A into 0 … 2^n−1, and negative inputs give 0. Either opcode raises an event when the value changed.
- R7: Opcodes 8 (signed) and 9 (unsigned) treat bits 15:0 and 31:16 of A as separate sign-extended halfwords and saturate each one as in R6. They return the low result in bits 15:0 and the high result in bits 31:16, and raise an event if either half clamped.
- R8: Opcodes 10 to 15 produce result 0 and no event.
- R9: On a clock edge with `in_valid` high and an event, `q_flag` becomes 1. It stays 1 until an edge with `q_clear` high. If a clear and an event occur on the same edge, the flag ends at 1.
- R10: `result` takes the new value on the clock edge where `in_valid` is high. It holds its value on edges where `in_valid` is low.
- R11: While `rst_n` is low, `result` and `q_flag` are 0. Reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code (see R1–R8) |
| opnd_a | input | 32 | First operand / value to saturate |
| opnd_b | input | 32 | Second operand |
| sat_pos | input | 5 | Saturation bit position n |
| q_clear | input | 1 | Clears the sticky flag |
| result | output | 32 | Operation result |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
Several properties are checked on every cycle: the flag stays set without a clear, the flag drops after a clear that has no concurrent event, the result has one cycle of latency and holds between strobes, signed add clamps only to one of the two rails, unsigned subtract clamps only to zero, and every position clamp stays inside its window. The exact values can only be shown by the bench's scenarios. These include the rail chosen by A's sign, the doubling thresholds at exactly 0xC0000000, halfword packing where only one half saturates, and the combined clear-with-event case.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [3:0] {
        OP_SADD  = 4'd0,
        OP_SSUB  = 4'd1,
        OP_UADD  = 4'd2,
        OP_USUB  = 4'd3,
        OP_QADD  = 4'd4,
        OP_DBL   = 4'd5,
        OP_SSAT  = 4'd6,
        OP_USAT  = 4'd7,
        OP_SSAT2 = 4'd8,
        OP_USAT2 = 4'd9
    } sat_op_e;

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
    import sat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  sat_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic              ev
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] POS_RAIL = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_RAIL = {1'b1, {(DATA_W-1){1'b0}}};

    logic              is_sub;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;
    logic [DATA_W-1:0] sum;
    logic              carry;
    logic              s_ovf;

    assign is_sub = (op == OP_SSUB) || (op == OP_USUB);
    assign b_eff  = is_sub ? ~b : b;
    assign wide   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, is_sub};
    assign sum    = wide[DATA_W-1:0];
    assign carry  = wide[DATA_W];
    // same-sign operands (after inversion for subtract) producing opposite-sign sum
    assign s_ovf  = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

    always_comb begin
        res = sum;
        ev  = 1'b0;
        unique case (op)
            OP_SADD, OP_SSUB: begin
                ev  = s_ovf;
                res = s_ovf ? (a[MSB] ? NEG_RAIL : POS_RAIL) : sum;
            end
            OP_QADD: begin
                ev  = s_ovf;
                res = sum;
            end
            OP_UADD: begin
                ev  = carry;
                res = carry ? {DATA_W{1'b1}} : sum;
            end
            OP_USUB: begin
                ev  = ~carry;
                res = carry ? sum : '0;
            end
            default: begin
                res = sum;
                ev  = 1'b0;
            end
        endcase
    end

    // R1: a clamped signed add lands on one of the two rails
    always_comb begin
        if (op == OP_SADD && ev)
            a_r1_sadd_rail: assert (res == POS_RAIL || res == NEG_RAIL);
    end

    // R3: a clamped unsigned subtract floors at zero
    always_comb begin
        if (op == OP_USUB && ev)
            a_r3_usub_floor: assert (res == '0);
    end

endmodule

// File: rtl/sat_doubler.sv
module sat_doubler #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    output logic [DATA_W-1:0] res,
    output logic              ev
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] POS_RAIL = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_RAIL = {1'b1, {(DATA_W-1){1'b0}}};

    logic hi_clip;
    logic lo_clip;

    // at or above a quarter of the range: non-negative with the next bit set
    assign hi_clip = ~a[MSB] & a[MSB-1];
    // at or below minus a quarter: negative and either bit MSB-1 clear or exactly the boundary
    assign lo_clip = a[MSB] & (~a[MSB-1] | (a[MSB-2:0] == '0));

    always_comb begin
        if (hi_clip) begin
            res = POS_RAIL;
            ev  = 1'b1;
        end else if (lo_clip) begin
            res = NEG_RAIL;
            ev  = 1'b1;
        end else begin
            res = {a[MSB-1:0], 1'b0};
            ev  = 1'b0;
        end
    end

endmodule

// File: rtl/sat_pos_clamp.sv
module sat_pos_clamp #(
    parameter int IN_W  = 32,
    parameter int POS_W = 5
) (
    input  logic [IN_W-1:0]  val,
    input  logic [POS_W-1:0] pos,
    input  logic             uns,
    output logic [IN_W-1:0]  res,
    output logic             ev
);
    localparam int EXT_W = (1 << POS_W) + 2;

    logic signed [EXT_W-1:0] vext;
    logic signed [EXT_W-1:0] lim;
    logic signed [EXT_W-1:0] lo;
    logic signed [EXT_W-1:0] sel;

    assign vext = {{(EXT_W-IN_W){val[IN_W-1]}}, val};
    assign lim  = (EXT_W'(1) << pos) - EXT_W'(1);
    assign lo   = uns ? '0 : ~lim;

    always_comb begin
        if (vext > lim) begin
            sel = lim;
            ev  = 1'b1;
        end else if (vext < lo) begin
            sel = lo;
            ev  = 1'b1;
        end else begin
            sel = vext;
            ev  = 1'b0;
        end
    end

    assign res = sel[IN_W-1:0];

    // R6: the selected value always lies inside the window for this position
    always_comb begin
        a_r6_window: assert (sel <= lim && sel >= lo);
    end

endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
    import sat_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter bit REGISTERED = 1'b1,
    localparam int POS_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [POS_W-1:0]  sat_pos,
    input  logic              q_clear,
    output logic [DATA_W-1:0] result,
    output logic              q_flag
);
    localparam int NUM_HALF = 2;
    localparam int HALF_W   = DATA_W / NUM_HALF;

    sat_op_e           op_e;
    logic [DATA_W-1:0] as_res, dbl_res, wd_res, comb_res;
    logic              as_ev, dbl_ev, wd_ev, comb_ev;
    logic [HALF_W-1:0] h_res [NUM_HALF];
    logic [NUM_HALF-1:0] h_ev;
    logic [DATA_W-1:0] h_pack;

    assign op_e = sat_op_e'(op);

    sat_addsub #(.DATA_W(DATA_W)) u_addsub (
        .op  (op_e),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (as_res),
        .ev  (as_ev)
    );

    sat_doubler #(.DATA_W(DATA_W)) u_dbl (
        .a   (opnd_a),
        .res (dbl_res),
        .ev  (dbl_ev)
    );

    sat_pos_clamp #(.IN_W(DATA_W), .POS_W(POS_W)) u_word (
        .val (opnd_a),
        .pos (sat_pos),
        .uns (op_e == OP_USAT),
        .res (wd_res),
        .ev  (wd_ev)
    );

    for (genvar k = 0; k < NUM_HALF; k++) begin : g_half
        sat_pos_clamp #(.IN_W(HALF_W), .POS_W(POS_W)) u_half (
            .val (opnd_a[k*HALF_W +: HALF_W]),
            .pos (sat_pos),
            .uns (op_e == OP_USAT2),
            .res (h_res[k]),
            .ev  (h_ev[k])
        );
        assign h_pack[k*HALF_W +: HALF_W] = h_res[k];
    end

    always_comb begin
        comb_res = '0;
        comb_ev  = 1'b0;
        unique case (op_e)
            OP_SADD, OP_SSUB, OP_UADD, OP_USUB, OP_QADD: begin
                comb_res = as_res;
                comb_ev  = as_ev;
            end
            OP_DBL: begin
                comb_res = dbl_res;
                comb_ev  = dbl_ev;
            end
            OP_SSAT, OP_USAT: begin
                comb_res = wd_res;
                comb_ev  = wd_ev;
            end
            OP_SSAT2, OP_USAT2: begin
                comb_res = h_pack;
                comb_ev  = |h_ev;
            end
            default: begin
                comb_res = '0;
                comb_ev  = 1'b0;
            end
        endcase
    end

    // sticky flag: a new event wins over a clear on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_flag <= 1'b0;
        else
            q_flag <= (q_flag & ~q_clear) | (in_valid & comb_ev);
    end

    if (REGISTERED) begin : g_reg
        logic [DATA_W-1:0] res_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                res_q <= '0;
            else if (in_valid)
                res_q <= comb_res;
        end
        assign result = res_q;

        // R10: the strobed value appears one edge later
        a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> result == $past(comb_res));
        // R10: the result holds between strobes
        a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(result));
    end else begin : g_comb
        assign result = comb_res;
    end

    // R9: without a clear the flag cannot fall
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q_flag && !q_clear |=> q_flag);
    // R9: a clear with no concurrent event leaves the flag low
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        q_clear && !(in_valid && comb_ev) |=> !q_flag);

endmodule

// File: tb/sim_sat_arith_unit.sv
`timescale 1ns/1ps
module sim_sat_arith_unit;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  n;
        logic [31:0] exp;
        logic        ev;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t TBL [NV] = '{
        '{4'd0, 32'h0000_0001, 32'h0000_0002, 5'd0,  32'h0000_0003, 1'b0},
        '{4'd0, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0,  32'h7FFF_FFFF, 1'b1},
        '{4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0,  32'h8000_0000, 1'b1},
        '{4'd0, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0,  32'hFFFF_FFFF, 1'b0},
        '{4'd1, 32'h8000_0000, 32'h0000_0001, 5'd0,  32'h8000_0000, 1'b1},
        '{4'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0,  32'h7FFF_FFFF, 1'b1},
        '{4'd1, 32'h0000_0005, 32'h0000_0007, 5'd0,  32'hFFFF_FFFE, 1'b0},
        '{4'd2, 32'hFFFF_FFF0, 32'h0000_0020, 5'd0,  32'hFFFF_FFFF, 1'b1},
        '{4'd2, 32'h0000_0010, 32'h0000_0020, 5'd0,  32'h0000_0030, 1'b0},
        '{4'd3, 32'h0000_0005, 32'h0000_0007, 5'd0,  32'h0000_0000, 1'b1},
        '{4'd3, 32'h0000_0007, 32'h0000_0005, 5'd0,  32'h0000_0002, 1'b0},
        '{4'd3, 32'h0000_0005, 32'h0000_0005, 5'd0,  32'h0000_0000, 1'b0},
        '{4'd4, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0,  32'h8000_0000, 1'b1},
        '{4'd4, 32'h0000_0010, 32'h0000_0020, 5'd0,  32'h0000_0030, 1'b0},
        '{4'd5, 32'h4000_0000, 32'h0,         5'd0,  32'h7FFF_FFFF, 1'b1},
        '{4'd5, 32'h3FFF_FFFF, 32'h0,         5'd0,  32'h7FFF_FFFE, 1'b0},
        '{4'd5, 32'hC000_0000, 32'h0,         5'd0,  32'h8000_0000, 1'b1},
        '{4'd5, 32'hC000_0001, 32'h0,         5'd0,  32'h8000_0002, 1'b0},
        '{4'd6, 32'h0000_1000, 32'h0,         5'd7,  32'h0000_007F, 1'b1},
        '{4'd6, 32'hFFFF_FF00, 32'h0,         5'd7,  32'hFFFF_FF80, 1'b1},
        '{4'd6, 32'hFFFF_FF80, 32'h0,         5'd7,  32'hFFFF_FF80, 1'b0},
        '{4'd6, 32'h8000_0000, 32'h0,         5'd31, 32'h8000_0000, 1'b0},
        '{4'd6, 32'h0000_0005, 32'h0,         5'd0,  32'h0000_0000, 1'b1},
        '{4'd7, 32'hFFFF_FFFF, 32'h0,         5'd8,  32'h0000_0000, 1'b1},
        '{4'd7, 32'h0000_0300, 32'h0,         5'd8,  32'h0000_00FF, 1'b1},
        '{4'd7, 32'h0000_00FF, 32'h0,         5'd8,  32'h0000_00FF, 1'b0},
        '{4'd7, 32'h7FFF_FFFF, 32'h0,         5'd31, 32'h7FFF_FFFF, 1'b0},
        '{4'd8, 32'h7FFF_8000, 32'h0,         5'd7,  32'h007F_FF80, 1'b1},
        '{4'd8, 32'h0010_FFF0, 32'h0,         5'd7,  32'h0010_FFF0, 1'b0},
        '{4'd8, 32'h1234_0005, 32'h0,         5'd3,  32'h0007_0005, 1'b1},
        '{4'd8, 32'h8000_7FFF, 32'h0,         5'd15, 32'h8000_7FFF, 1'b0},
        '{4'd9, 32'h8000_0100, 32'h0,         5'd4,  32'h0000_000F, 1'b1},
        '{4'd9, 32'h0003_000C, 32'h0,         5'd4,  32'h0003_000C, 1'b0},
        '{4'd9, 32'hFFFF_7FFF, 32'h0,         5'd15, 32'h0000_7FFF, 1'b1},
        '{4'd15, 32'h0000_1234, 32'h0000_0001, 5'd0, 32'h0000_0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  op;
    logic [31:0] opnd_a, opnd_b;
    logic [4:0]  sat_pos;
    logic        q_clear;
    logic [31:0] result;
    logic        q_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sat_arith_unit u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .op       (op),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .sat_pos  (sat_pos),
        .q_clear  (q_clear),
        .result   (result),
        .q_flag   (q_flag)
    );

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6, 4'd7: return "R6";
            4'd8, 4'd9: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic strobe(input logic [3:0] o, input logic [31:0] a,
                          input logic [31:0] b, input logic [4:0] n, input logic clr);
        @(negedge clk);
        op = o; opnd_a = a; opnd_b = b; sat_pos = n;
        in_valid = 1'b1; q_clear = clr;
        @(negedge clk);
        in_valid = 1'b0; q_clear = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        q_clear = 1'b1;
        @(negedge clk);
        q_clear = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; q_clear = 1'b0;
        op = '0; opnd_a = '0; opnd_b = '0; sat_pos = '0;
        repeat (3) @(negedge clk);
        check("R11", "reset result", result, 32'h0);
        check("R11", "reset flag", {31'b0, q_flag}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            clear_flag();
            strobe(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].n, 1'b0);
            check(tag_of(TBL[i].op), $sformatf("vector %0d result", i), result, TBL[i].exp);
            check(tag_of(TBL[i].op), $sformatf("vector %0d flag", i),
                  {31'b0, q_flag}, {31'b0, TBL[i].ev});
        end

        // R9: flag survives a later non-saturating operation
        clear_flag();
        strobe(4'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, 1'b0);
        strobe(4'd0, 32'h1, 32'h2, 5'd0, 1'b0);
        check("R9", "sticky result", result, 32'h3);
        check("R9", "sticky flag", {31'b0, q_flag}, 32'h1);

        // R10: no strobe -> result and flag untouched despite saturating inputs
        @(negedge clk);
        op = 4'd2; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R10", "hold result", result, 32'h3);
        check("R10", "hold flag", {31'b0, q_flag}, 32'h1);

        // R9: clear alone drops the flag
        clear_flag();
        check("R9", "clear flag", {31'b0, q_flag}, 32'h0);

        // R9: clear with a concurrent event leaves the flag set
        strobe(4'd2, 32'hFFFF_FFFF, 32'h2, 5'd0, 1'b1);
        check("R9", "clear+event flag", {31'b0, q_flag}, 32'h1);
        check("R3", "clear+event result", result, 32'hFFFF_FFFF);

        // R11: asynchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11", "async reset result", result, 32'h0);
        check("R11", "async reset flag", {31'b0, q_flag}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule